// File: doc/BRIEF.md
# Serial Flash Command and Address Decoder

This block sits behind the bit shifter of a serial flash target. It receives the bytes a host shifts in and works out what the host wants. The first byte after select goes low is taken as an opcode. The decoder then gathers the address bytes that opcode needs, and any dummy bytes after them. It then issues one request with a complete byte address: a read, a program or one of three erase sizes. After a read or program request, each further byte in the same select becomes one array access, and the address steps up by one each time.

The address length depends on both the opcode and the mode. Opcodes with explicit 4-byte addressing always take four bytes. The older opcodes take four bytes when a sticky 4-byte mode is on and three when it is off. A strap input selects a small-memory mode in which every command takes two bytes. A 3-byte address is banked: the low two bits of an internal bank register select one of four 16 MiB windows. Fast and multi-lane reads insert a number of dummy bytes taken from a configuration input. A flag status opcode and a bank register read present a byte for the shifter to send.

States: `ST_IDLE` (waits for an opcode), `ST_COLLECT` (address, dummy or register data bytes), `ST_READ` (streaming read), `ST_PROG` (page program), `ST_REGOUT` (register byte presented) and `ST_SKIP` (unknown opcode, waits for deselect). Transitions:
- In every state, deselect moves the decoder to `ST_IDLE`.
- From `ST_IDLE`, an addressed opcode or a bank write moves to `ST_COLLECT`.
- From `ST_IDLE`, a register read moves to `ST_REGOUT`.
- From `ST_IDLE`, a mode opcode stays in `ST_IDLE`.
- From `ST_IDLE`, an unknown opcode moves to `ST_SKIP`.
- From `ST_COLLECT`, the last needed byte moves to `ST_READ`, to `ST_PROG` or back to `ST_IDLE`, depending on the opcode class.

Top module: `spi_flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is idle, no request output pulses, 4-byte mode is off and the bank register reads 0x00.
- R2: The older opcodes take 3 address bytes when 4-byte mode is off, assembled most significant byte first: read 0x03, program 0x02, 4 KiB erase 0x20, 32 KiB erase 0x52 and sector erase 0xD8. One clock after the last address byte, `cmd_valid` pulses for one cycle with `cmd_kind` and `cmd_addr`. The `cmd_kind` codes are read 1, program 2, 4 KiB erase 3, 32 KiB erase 4 and sector erase 5.
- R3: The explicit 4-byte opcodes always take 4 address bytes: 0x13, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC, 0x12, 0x21 and 0xDC. Address bits above ADDR_W are dropped.
- R4: Opcode 0xB7 turns 4-byte mode on and opcode 0xE9 turns it off. While 4-byte mode is on, the older opcodes take 4 address bytes.
- R5: While `two_byte_addr` is high, every addressed opcode takes exactly 2 address bytes, and no bank is added.
- R6: Opcode 0xC5 writes the next byte into the bank register, and opcode 0xC8 presents that register on `tx_byte`. A 3-byte address gets bank[1:0] x 0x1000000 added to it; a 4-byte address gets nothing added.
- R7: Fast and multi-lane reads (0x0B, 0x3B, 0x6B, 0xBB, 0xEB and their 4-byte forms) collect `vcfg[7:4]` dummy bytes after the address. Plain reads collect none.
- R8: In the read state, each byte received pulses `rd_req` with `rd_addr` set to the current address. The address then increments and wraps from 2^ADDR_W-1 to 0.
- R9: In the program state, each byte received pulses `wr_req` with that byte on `wr_data` and the current address on `wr_addr`. The address then increments.
- R10: An erase request returns the decoder to idle, so the next byte in the same select is decoded as a new opcode.
- R11: Opcode 0x70 presents a flag byte on `tx_byte` with `reg_valid` high. Bit 7 is 1 (ready), bit 0 equals 4-byte mode, and all other bits are 0.
- R12: An unknown opcode makes the decoder ignore all bytes until `cs_n` rises. A high `cs_n` always returns the decoder to idle and abandons any partial command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Target select, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| two_byte_addr | input | 1 | Strap: all commands take 2 address bytes |
| vcfg | input | 8 | Volatile configuration; bits 7:4 give the dummy byte count |
| cmd_valid | output | 1 | One-cycle pulse when a command's address is complete |
| cmd_kind | output | 3 | Request type, coded as in R2 |
| cmd_addr | output | ADDR_W | Fully formed byte address |
| rd_req | output | 1 | Pulse for each streamed read byte |
| rd_addr | output | ADDR_W | Read address |
| wr_req | output | 1 | Pulse for each programmed byte |
| wr_addr | output | ADDR_W | Program address |
| wr_data | output | 8 | Program data |
| reg_valid | output | 1 | A register byte is presented |
| tx_byte | output | 8 | Register byte to send |

## Verification
Two things can happen on the same byte. The last collected byte finishes the address and also updates the bank register or the mode, depending on the opcode. The byte that ends an erase also frees the decoder to decode a new opcode in the same select. The bench provokes the first case with a bank write followed by a banked read. It provokes the second with an erase followed at once by a flag status opcode without deselecting. It judges each case by the request address and by the register byte presented at the next sample point.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [3:0] {
        OC_NONE,
        OC_READ,
        OC_PROG,
        OC_ER4K,
        OC_ER32K,
        OC_ERSEC,
        OC_EN4B,
        OC_EX4B,
        OC_WBANK,
        OC_RBANK,
        OC_RFLAG
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      force4;
        logic      dummy;
    } op_info_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_READ,
        ST_PROG,
        ST_REGOUT,
        ST_SKIP
    } state_e;

    localparam logic [2:0] KIND_NONE  = 3'd0;
    localparam logic [2:0] KIND_READ  = 3'd1;
    localparam logic [2:0] KIND_PROG  = 3'd2;
    localparam logic [2:0] KIND_ER4K  = 3'd3;
    localparam logic [2:0] KIND_ER32K = 3'd4;
    localparam logic [2:0] KIND_ERSEC = 3'd5;

    function automatic logic [2:0] kind_of(input op_class_e c);
        case (c)
            OC_READ:  kind_of = KIND_READ;
            OC_PROG:  kind_of = KIND_PROG;
            OC_ER4K:  kind_of = KIND_ER4K;
            OC_ER32K: kind_of = KIND_ER32K;
            OC_ERSEC: kind_of = KIND_ERSEC;
            default:  kind_of = KIND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sfd_op_decode.sv
module sfd_op_decode
    import sfd_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);

    always_comb begin
        info = '{cls: OC_NONE, force4: 1'b0, dummy: 1'b0};
        case (opcode)
            8'h03: info.cls = OC_READ;
            8'h13: begin info.cls = OC_READ; info.force4 = 1'b1; end
            8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB: begin
                info.cls   = OC_READ;
                info.dummy = 1'b1;
            end
            8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC: begin
                info.cls    = OC_READ;
                info.dummy  = 1'b1;
                info.force4 = 1'b1;
            end
            8'h02, 8'hA2, 8'h32: info.cls = OC_PROG;
            8'h12: begin info.cls = OC_PROG; info.force4 = 1'b1; end
            8'h20: info.cls = OC_ER4K;
            8'h21: begin info.cls = OC_ER4K; info.force4 = 1'b1; end
            8'h52: info.cls = OC_ER32K;
            8'hD8: info.cls = OC_ERSEC;
            8'hDC: begin info.cls = OC_ERSEC; info.force4 = 1'b1; end
            8'hB7: info.cls = OC_EN4B;
            8'hE9: info.cls = OC_EX4B;
            8'hC5: info.cls = OC_WBANK;
            8'hC8: info.cls = OC_RBANK;
            8'h70: info.cls = OC_RFLAG;
            default: info.cls = OC_NONE;
        endcase
    end

endmodule

// File: rtl/sfd_addr_build.sv
module sfd_addr_build #(
    parameter int ADDR_W = 26
) (
    input  logic [31:0]       acc,
    input  logic [2:0]        alen,
    input  logic [1:0]        bank,
    output logic [ADDR_W-1:0] addr
);

    localparam int BANK_SHIFT = 24;

    logic [31:0] offset;
    logic [31:0] full;

    always_comb begin
        offset = '0;
        if (alen == 3'd3) begin
            offset = {30'd0, bank} << BANK_SHIFT;
        end
        full = acc + offset;
        addr = full[ADDR_W-1:0];
    end

endmodule

// File: rtl/sfd_mode_regs.sv
module sfd_mode_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set4b,
    input  logic       clr4b,
    input  logic       bank_we,
    input  logic [7:0] bank_din,
    output logic       mode4b,
    output logic [7:0] bank
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode4b <= 1'b0;
            bank   <= 8'h00;
        end else begin
            if (set4b) begin
                mode4b <= 1'b1;
            end else if (clr4b) begin
                mode4b <= 1'b0;
            end
            if (bank_we) begin
                bank <= bank_din;
            end
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank)); // R6
    AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set4b |=> mode4b); // R4
    AST_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr4b && !set4b) |=> !mode4b); // R4

endmodule

// File: rtl/spi_flash_cmd_decoder.sv
module spi_flash_cmd_decoder
    import sfd_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              two_byte_addr,
    input  logic [7:0]        vcfg,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              reg_valid,
    output logic [7:0]        tx_byte
);

    localparam int CNT_W = 5;

    state_e            state_q, state_d;
    op_class_e         cls_q;
    logic [2:0]        alen_q;
    logic [CNT_W-1:0]  need_q;
    logic [CNT_W-1:0]  idx_q;
    logic [31:0]       acc_q;
    logic [ADDR_W-1:0] cur_q;

    op_info_t          info;
    logic              byte_in;
    logic [2:0]        alen_new;
    logic [CNT_W-1:0]  need_new;
    logic [31:0]       acc_nxt;
    logic              last;
    logic [ADDR_W-1:0] final_addr;
    logic              mode4b;
    logic [7:0]        bank;
    logic              set4b, clr4b, bank_we;

    sfd_op_decode u_dec (
        .opcode (rx_byte),
        .info   (info)
    );

    sfd_addr_build #(.ADDR_W(ADDR_W)) u_addr (
        .acc  (acc_nxt),
        .alen (alen_q),
        .bank (bank[1:0]),
        .addr (final_addr)
    );

    sfd_mode_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set4b    (set4b),
        .clr4b    (clr4b),
        .bank_we  (bank_we),
        .bank_din (acc_nxt[7:0]),
        .mode4b   (mode4b),
        .bank     (bank)
    );

    always_comb begin
        byte_in = rx_valid && !cs_n;
        if (info.cls == OC_WBANK) begin
            alen_new = 3'd1;
        end else if (two_byte_addr) begin
            alen_new = 3'd2;
        end else if (info.force4 || mode4b) begin
            alen_new = 3'd4;
        end else begin
            alen_new = 3'd3;
        end
        need_new = {2'b00, alen_new} + (info.dummy ? {1'b0, vcfg[7:4]} : '0);
        acc_nxt  = (idx_q < {2'b00, alen_q}) ? {acc_q[23:0], rx_byte} : acc_q;
        last     = (idx_q == need_q - 1'b1);
        set4b    = byte_in && (state_q == ST_IDLE) && (info.cls == OC_EN4B);
        clr4b    = byte_in && (state_q == ST_IDLE) && (info.cls == OC_EX4B);
        bank_we  = byte_in && (state_q == ST_COLLECT) && last && (cls_q == OC_WBANK);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    case (info.cls)
                        OC_READ, OC_PROG, OC_ER4K, OC_ER32K, OC_ERSEC, OC_WBANK:
                            state_d = ST_COLLECT;
                        OC_RBANK, OC_RFLAG: state_d = ST_REGOUT;
                        OC_EN4B, OC_EX4B:   state_d = ST_IDLE;
                        default:            state_d = ST_SKIP;
                    endcase
                end
                ST_COLLECT: begin
                    if (last) begin
                        if (cls_q == OC_READ) begin
                            state_d = ST_READ;
                        end else if (cls_q == OC_PROG) begin
                            state_d = ST_PROG;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_READ, ST_PROG, ST_REGOUT, ST_SKIP: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q     <= OC_NONE;
            alen_q    <= 3'd3;
            need_q    <= '0;
            idx_q     <= '0;
            acc_q     <= '0;
            cur_q     <= '0;
            cmd_valid <= 1'b0;
            cmd_kind  <= KIND_NONE;
            cmd_addr  <= '0;
            rd_req    <= 1'b0;
            rd_addr   <= '0;
            wr_req    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            tx_byte   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            if (byte_in) begin
                case (state_q)
                    ST_IDLE: begin
                        cls_q  <= info.cls;
                        alen_q <= alen_new;
                        need_q <= need_new;
                        idx_q  <= '0;
                        acc_q  <= '0;
                        if (info.cls == OC_RBANK) begin
                            tx_byte <= bank;
                        end else if (info.cls == OC_RFLAG) begin
                            tx_byte <= {1'b1, 6'b000000, mode4b};
                        end
                    end
                    ST_COLLECT: begin
                        acc_q <= acc_nxt;
                        idx_q <= idx_q + 1'b1;
                        if (last && (kind_of(cls_q) != KIND_NONE)) begin
                            cmd_valid <= 1'b1;
                            cmd_kind  <= kind_of(cls_q);
                            cmd_addr  <= final_addr;
                            cur_q     <= final_addr;
                        end
                    end
                    ST_READ: begin
                        rd_req  <= 1'b1;
                        rd_addr <= cur_q;
                        cur_q   <= cur_q + 1'b1;
                    end
                    ST_PROG: begin
                        wr_req  <= 1'b1;
                        wr_addr <= cur_q;
                        wr_data <= rx_byte;
                        cur_q   <= cur_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_valid = (state_q == ST_REGOUT);

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, rd_req, wr_req})); // R8
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state_q == ST_IDLE)); // R12
    AST_CMD_AFTER_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> ($past(state_q) == ST_COLLECT)); // R2
    AST_STREAM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && byte_in) |=> rd_req); // R8
    AST_STREAM_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && byte_in) |=> (wr_req && wr_data == $past(rx_byte))); // R9
    AST_ERASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind >= KIND_ER4K) |-> (state_q == ST_IDLE)); // R10
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |=> !cmd_valid); // R12

endmodule

// File: tb/tb_spi_flash_cmd_decoder.sv
module tb_spi_flash_cmd_decoder;

    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          two_byte_addr = 1'b0;
    logic [7:0]    vcfg = 8'h20;
    logic          cmd_valid;
    logic [2:0]    cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          reg_valid;
    logic [7:0]    tx_byte;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_flash_cmd_decoder #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .two_byte_addr(two_byte_addr), .vcfg(vcfg),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .reg_valid(reg_valid), .tx_byte(tx_byte)
    );

    typedef struct packed {
        logic [63:0] b;
        logic [3:0]  n;
        logic [31:0] addr;
        logic [2:0]  kind;
    } vec_t;

    // vcfg = 0x20 gives 2 dummy bytes
    localparam vec_t VEC [0:12] = '{
        '{64'h03123456_00000000, 4'd4, 32'h00123456, 3'd1},
        '{64'h020000FF_00000000, 4'd4, 32'h000000FF, 3'd2},
        '{64'h20ABCDEF_00000000, 4'd4, 32'h00ABCDEF, 3'd3},
        '{64'h52010203_00000000, 4'd4, 32'h00010203, 3'd4},
        '{64'hD8FFFFFF_00000000, 4'd4, 32'h00FFFFFF, 3'd5},
        '{64'h13012345_67000000, 4'd5, 32'h01234567, 3'd1},
        '{64'h12FF0000_10000000, 4'd5, 32'h03000010, 3'd2},
        '{64'h21000010_00000000, 4'd5, 32'h00001000, 3'd3},
        '{64'hDC020000_00000000, 4'd5, 32'h02000000, 3'd5},
        '{64'h0B001000_AABB0000, 4'd6, 32'h00001000, 3'd1},
        '{64'h0C000000_44AABB00, 4'd7, 32'h00000044, 3'd1},
        '{64'h3B112233_AABB0000, 4'd6, 32'h00112233, 3'd1},
        '{64'hEC010000_00AABB00, 4'd7, 32'h01000000, 3'd1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic desel();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_cmd(input string req, input logic [31:0] a, input logic [2:0] k);
        chk(req, "cmd_valid", {31'd0, cmd_valid}, 32'd1);
        chk(req, "cmd_addr", {6'd0, cmd_addr}, a);
        chk(req, "cmd_kind", {29'd0, cmd_kind}, {29'd0, k});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "cmd_valid", {31'd0, cmd_valid}, 32'd0);
        chk("R1", "rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1", "wr_req", {31'd0, wr_req}, 32'd0);
        chk("R1", "reg_valid", {31'd0, reg_valid}, 32'd0);
        sel(); send(8'h70);
        chk("R1", "flag byte", {24'd0, tx_byte}, 32'h80);
        desel();
        sel(); send(8'hC8);
        chk("R1", "bank", {24'd0, tx_byte}, 32'h00);
        desel();

        // table walk: R2, R3, R7
        for (int i = 0; i < 13; i++) begin
            tag = (i < 5) ? "R2" : ((i < 9) ? "R3" : "R7");
            sel();
            for (int j = 0; j < int'(VEC[i].n); j++) begin
                send(VEC[i].b[63-8*j -: 8]);
                if (j == int'(VEC[i].n) - 1) begin
                    expect_cmd(tag, VEC[i].addr, VEC[i].kind);
                end else begin
                    chk(tag, "early cmd_valid", {31'd0, cmd_valid}, 32'd0);
                end
            end
            desel();
        end

        // R4 global 4-byte mode
        sel(); send(8'hB7); desel();
        sel(); send(8'h70);
        chk("R4", "flag 4B on", {24'd0, tx_byte}, 32'h81);
        desel();
        sel(); send(8'h03); send(8'h00); send(8'h12); send(8'h34);
        chk("R4", "no pulse after 3 bytes", {31'd0, cmd_valid}, 32'd0);
        send(8'h56);
        expect_cmd("R4", 32'h00123456, 3'd1);
        desel();
        sel(); send(8'hE9); desel();
        sel(); send(8'h70);
        chk("R11", "flag 4B off", {24'd0, tx_byte}, 32'h80);
        chk("R11", "reg_valid", {31'd0, reg_valid}, 32'd1);
        desel();
        sel(); send(8'h20); send(8'h00); send(8'h00); send(8'h08);
        expect_cmd("R4", 32'h00000008, 3'd3);
        desel();

        // R6 banking
        sel(); send(8'hC5); send(8'h02); desel();
        sel(); send(8'hC8);
        chk("R6", "bank readback", {24'd0, tx_byte}, 32'h02);
        desel();
        sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h10);
        expect_cmd("R6", 32'h02000010, 3'd1);
        desel();
        sel(); send(8'h13); send(8'h00); send(8'h00); send(8'h00); send(8'h10);
        expect_cmd("R6", 32'h00000010, 3'd1);
        desel();
        sel(); send(8'hC5); send(8'h00); desel();

        // R5 two-byte strap
        two_byte_addr = 1'b1;
        sel(); send(8'h03); send(8'h12); send(8'h34);
        expect_cmd("R5", 32'h00001234, 3'd1);
        desel();
        sel(); send(8'h12); send(8'hAB); send(8'hCD);
        expect_cmd("R5", 32'h0000ABCD, 3'd2);
        desel();
        two_byte_addr = 1'b0;

        // R7 dummy count from config; plain read unaffected
        vcfg = 8'h10;
        sel(); send(8'hBB); send(8'h00); send(8'h00); send(8'h20);
        chk("R7", "pulse waits for dummy", {31'd0, cmd_valid}, 32'd0);
        send(8'hFF);
        expect_cmd("R7", 32'h00000020, 3'd1);
        desel();
        vcfg = 8'h20;

        // R8 streaming read with wrap
        sel(); send(8'h13); send(8'h03); send(8'hFF); send(8'hFF); send(8'hFE);
        expect_cmd("R8", 32'h03FFFFFE, 3'd1);
        send(8'h00);
        chk("R8", "rd_req", {31'd0, rd_req}, 32'd1);
        chk("R8", "rd_addr 0", {6'd0, rd_addr}, 32'h03FFFFFE);
        send(8'h00);
        chk("R8", "rd_addr 1", {6'd0, rd_addr}, 32'h03FFFFFF);
        send(8'h00);
        chk("R8", "rd_addr wrap", {6'd0, rd_addr}, 32'h00000000);
        desel();

        // R9 page program
        sel(); send(8'h02); send(8'h00); send(8'h01); send(8'h00);
        expect_cmd("R9", 32'h00000100, 3'd2);
        send(8'hA5);
        chk("R9", "wr_req", {31'd0, wr_req}, 32'd1);
        chk("R9", "wr_addr", {6'd0, wr_addr}, 32'h100);
        chk("R9", "wr_data", {24'd0, wr_data}, 32'hA5);
        send(8'h5A);
        chk("R9", "wr_addr next", {6'd0, wr_addr}, 32'h101);
        chk("R9", "wr_data next", {24'd0, wr_data}, 32'h5A);
        desel();

        // R10 erase then new opcode in same select
        sel(); send(8'hD8); send(8'h01); send(8'h00); send(8'h00);
        expect_cmd("R10", 32'h00010000, 3'd5);
        send(8'h70);
        chk("R10", "reg_valid after erase", {31'd0, reg_valid}, 32'd1);
        chk("R10", "flag after erase", {24'd0, tx_byte}, 32'h80);
        desel();

        // R12 unknown opcode ignored
        sel(); send(8'hFF); send(8'h03); send(8'h00); send(8'h00);
        send(8'h01);
        chk("R12", "no cmd after unknown", {31'd0, cmd_valid}, 32'd0);
        send(8'h70);
        chk("R12", "no reg after unknown", {31'd0, reg_valid}, 32'd0);
        desel();
        // R12 deselect abandons partial command
        sel(); send(8'h03); send(8'h12); desel();
        sel(); send(8'h70);
        chk("R12", "idle after abort", {31'd0, reg_valid}, 32'd1);
        desel();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule